// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block is the FIFO control stage of a 16550-compatible serial port. It holds a 16-entry transmit queue and a 16-entry receive queue, both controlled by a single write-only control byte from the host. The control byte enables FIFO mode, discards the contents of either queue, and selects the fill level at which the receive side asks for service. The transmit queue feeds a shift-register holding stage. The receive queue is filled by the receive deserializer, and the host drains it. A flag output tells the interrupt logic that the receive queue has reached the selected level.

Discarding the transmit queue removes only the bytes still waiting in it. A byte already handed to the shift register stays there and is sent to the end. The two discard bits act once per write and leave nothing behind. With FIFO mode off, each side holds one byte, like a plain holding register.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: A control write with bit 2 set empties the transmit queue, so `txCount` reads 0 right after that clock edge. A host transmit byte presented in the same cycle is discarded.
- R2: A transmit discard leaves `txShiftValid` and `txShiftData` unchanged, and no byte is loaded into the shift register in the cycle of the discard.
- R3: The discard bits clear themselves. A later control write with bits 2 and 1 at 0 removes nothing from either queue, and the other fields of the discarding write take effect normally.
- R4: A control write with bit 1 set empties the receive queue, so `rxCount` reads 0 after that edge. `rxDout` keeps its last value and the transmit side is not affected.
- R5: Control bits 3, 4 and 5 have no effect. A write that differs only in these bits leaves the same mode, trigger level and queue counts.
- R6: Control bits 7:6 select the receive trigger level: 00 selects 1 byte, 01 selects 4 bytes, 10 selects 8 bytes, 11 selects 14 bytes. The selection is held from the latest control write, and reset selects 00.
- R7: `rxTrig` is high exactly when FIFO mode is on and `rxCount` is greater than or equal to the selected trigger level.
- R8: Control bit 0 sets FIFO mode, which is shown on `fifoMode`. With bit 0 at 0, each queue accepts at most one byte and `rxTrig` stays low.
- R9: A host transmit byte arriving while the transmit queue is at capacity is dropped, and the count does not change.
- R10: A pulse on `rxRe` with data present puts the oldest byte on `rxDout` after the next edge and lowers `rxCount` by one. A read from an empty queue leaves `rxDout` and `rxCount` unchanged.
- R11: A received byte arriving while the receive queue is at capacity is dropped. The queued bytes are read out afterwards in arrival order.
- R12: While `txShiftValid` is low and the transmit queue holds data, the oldest byte moves into the shift register at the next edge. A pulse on `txShiftDone` lowers `txShiftValid` at the next edge.
- R13: After reset, both counts are 0, FIFO mode is off, `rxTrig`, `txShiftValid` and `rxDout` are 0, and the trigger selection is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlData | input | 8 | Control byte |
| txWe | input | 1 | Host transmit byte write strobe |
| txData | input | 8 | Host transmit byte |
| txShiftDone | input | 1 | Shift register finished its character |
| rxWe | input | 1 | Deserializer delivers a received byte |
| rxData | input | 8 | Received byte |
| rxRe | input | 1 | Host reads one received byte |
| rxDout | output | 8 | Last byte read from the receive queue |
| txShiftValid | output | 1 | Shift register holds a character |
| txShiftData | output | 8 | Character in the shift register |
| txCount | output | 5 | Bytes waiting in the transmit queue |
| rxCount | output | 5 | Bytes waiting in the receive queue |
| fifoMode | output | 1 | FIFO mode is enabled |
| rxTrig | output | 1 | Receive fill has reached the trigger level |

## Verification
The hardest case to reach is a transmit discard with the queue full and a character still held in the shift register. The shift register takes the first byte at once, so filling the queue needs seventeen back-to-back host writes while `txShiftDone` is held low. One more write then checks the drop. The discard is issued in that state, and the bench checks that the held character survives and that the next byte loaded comes from writes made after the discard. The trigger levels are covered by filling the receive queue one byte at a time for each of the four selections.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

  // Control byte bit positions the decoder depends on
  localparam int CB_FIFO_EN = 0;
  localparam int CB_RX_CLR  = 1;
  localparam int CB_TX_CLR  = 2;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_FOUR     = 2'b01,
    TRIG_EIGHT    = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_e;

  // Strobes and held settings from control to datapath
  typedef struct packed {
    logic      txClr;
    logic      rxClr;
    logic      fifoEn;
    trig_sel_e trigSel;
  } ufc_strobe_t;

  function automatic int trigBytes(trig_sel_e sel);
    unique case (sel)
      TRIG_ONE:      return 1;
      TRIG_FOUR:     return 4;
      TRIG_EIGHT:    return 8;
      default:       return 14;
    endcase
  endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] cap,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          pushOk, popOk;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pushOk = push && !clr && (count < cap);
  assign popOk  = pop && !clr && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      unique case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ufc_ctrl.sv
module ufc_ctrl
  import ufc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWe,
  input  logic [1:0]  trigBits,
  input  logic [2:0]  lowBits,
  output ufc_strobe_t strb
);

  logic      fifoEnQ;
  trig_sel_e trigSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ  <= 1'b0;
      trigSelQ <= TRIG_ONE;
    end else if (ctrlWe) begin
      fifoEnQ  <= lowBits[CB_FIFO_EN];
      trigSelQ <= trig_sel_e'(trigBits);
    end
  end

  // Discard strobes live only in the write cycle: nothing is stored
  always_comb begin
    strb.txClr   = ctrlWe && lowBits[CB_TX_CLR];
    strb.rxClr   = ctrlWe && lowBits[CB_RX_CLR];
    strb.fifoEn  = fifoEnQ;
    strb.trigSel = trigSelQ;
  end

endmodule

// File: rtl/ufc_datapath.sv
module ufc_datapath
  import ufc_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ufc_strobe_t   strb,
  input  logic          txWe,
  input  logic [W-1:0]  txData,
  input  logic          txShiftDone,
  input  logic          rxWe,
  input  logic [W-1:0]  rxData,
  input  logic          rxRe,
  output logic [W-1:0]  rxDout,
  output logic          txShiftValid,
  output logic [W-1:0]  txShiftData,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          rxTrig
);

  localparam logic [CW-1:0] FULL_CAP = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_CAP  = CW'(1);

  logic [CW-1:0] cap;
  logic [W-1:0]  txHead, rxHead;
  logic          txLoad, rxPop;
  logic [CW-1:0] trigLvl;
  int            rawLvl;

  assign cap = strb.fifoEn ? FULL_CAP : ONE_CAP;

  assign txLoad = !txShiftValid && (txCount != '0) && !strb.txClr;
  assign rxPop  = rxRe && (rxCount != '0) && !strb.rxClr;

  ufc_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strb.txClr),
    .push  (txWe),
    .pop   (txLoad),
    .din   (txData),
    .cap   (cap),
    .dout  (txHead),
    .count (txCount)
  );

  ufc_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strb.rxClr),
    .push  (rxWe),
    .pop   (rxPop),
    .din   (rxData),
    .cap   (cap),
    .dout  (rxHead),
    .count (rxCount)
  );

  // Shift register holding stage: only load and done touch it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftValid <= 1'b0;
      txShiftData  <= '0;
    end else if (txLoad) begin
      txShiftValid <= 1'b1;
      txShiftData  <= txHead;
    end else if (txShiftDone) begin
      txShiftValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rxDout <= '0;
    else if (rxPop) rxDout <= rxHead;
  end

  always_comb begin
    rawLvl  = trigBytes(strb.trigSel);
    trigLvl = (rawLvl > DEPTH) ? FULL_CAP : CW'(rawLvl);
    rxTrig  = strb.fifoEn && (rxCount >= trigLvl);
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import ufc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [7:0]    ctrlData,
  input  logic          txWe,
  input  logic [7:0]    txData,
  input  logic          txShiftDone,
  input  logic          rxWe,
  input  logic [7:0]    rxData,
  input  logic          rxRe,
  output logic [7:0]    rxDout,
  output logic          txShiftValid,
  output logic [7:0]    txShiftData,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          fifoMode,
  output logic          rxTrig
);

  ufc_strobe_t strb;

  ufc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .trigBits (ctrlData[7:6]),
    .lowBits  (ctrlData[2:0]),
    .strb     (strb)
  );

  ufc_datapath #(.W(8), .DEPTH(DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .txWe         (txWe),
    .txData       (txData),
    .txShiftDone  (txShiftDone),
    .rxWe         (rxWe),
    .rxData       (rxData),
    .rxRe         (rxRe),
    .rxDout       (rxDout),
    .txShiftValid (txShiftValid),
    .txShiftData  (txShiftData),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .rxTrig       (rxTrig)
  );

  assign fifoMode = strb.fifoEn;

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctrlWe,
  input logic [7:0]    ctrlData,
  input logic          txShiftDone,
  input logic          rxWe,
  input logic          rxRe,
  input logic [7:0]    rxDout,
  input logic          txShiftValid,
  input logic [7:0]    txShiftData,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic          fifoMode,
  input logic          rxTrig
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  a_r1_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlData[2] |=> txCount == '0);

  a_r2_shift_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlData[2] && !txShiftDone |=> $stable(txShiftValid) && $stable(txShiftData));

  a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlData[1] |=> rxCount == '0 && $stable(rxDout));

  a_r5_reserved_bits: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && (ctrlData[5:3] != 3'b000) && !ctrlData[1] && !rxWe && !rxRe
    |=> rxCount == $past(rxCount));

  a_r6_level_one: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlData[7:6] == 2'b00 && ctrlData[0] && !ctrlData[1] && rxCount != '0 && !rxRe
    |=> rxTrig);

  a_r7_trig_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    rxTrig |-> fifoMode && rxCount != '0);

  a_r8_mode_bit: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> fifoMode == $past(ctrlData[0]));

  a_r8_no_trig_plain: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode |-> !rxTrig);

  a_r9_tx_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    txCount == FULL && txShiftValid && !(ctrlWe && ctrlData[2]) |=> txCount == FULL);

  a_r9_tx_bound: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= FULL);

  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    rxRe && rxCount == '0 |=> $stable(rxDout));

  a_r11_rx_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    rxCount == FULL && !rxRe && !(ctrlWe && ctrlData[1]) |=> rxCount == FULL);

  a_r12_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    txShiftValid && txShiftDone |=> !txShiftValid);

endmodule

bind uart_fifo_ctrl ufc_checker #(.DEPTH(DEPTH)) u_ufc_checker (
  .clk          (clk),
  .rstN         (rstN),
  .ctrlWe       (ctrlWe),
  .ctrlData     (ctrlData),
  .txShiftDone  (txShiftDone),
  .rxWe         (rxWe),
  .rxRe         (rxRe),
  .rxDout       (rxDout),
  .txShiftValid (txShiftValid),
  .txShiftData  (txShiftData),
  .txCount      (txCount),
  .rxCount      (rxCount),
  .fifoMode     (fifoMode),
  .rxTrig       (rxTrig)
);

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWe = 1'b0, txWe = 1'b0, txShiftDone = 1'b0;
  logic          rxWe = 1'b0, rxRe = 1'b0;
  logic [7:0]    ctrlData = '0, txData = '0, rxData = '0;
  logic [7:0]    rxDout, txShiftData;
  logic          txShiftValid, fifoMode, rxTrig;
  logic [CW-1:0] txCount, rxCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .txWe(txWe), .txData(txData), .txShiftDone(txShiftDone),
    .rxWe(rxWe), .rxData(rxData), .rxRe(rxRe), .rxDout(rxDout),
    .txShiftValid(txShiftValid), .txShiftData(txShiftData),
    .txCount(txCount), .rxCount(rxCount), .fifoMode(fifoMode), .rxTrig(rxTrig)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FIFO-CTRL FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctrlWrite(logic [7:0] v);
    ctrlWe = 1'b1; ctrlData = v; step(); ctrlWe = 1'b0;
  endtask

  task automatic txWrite(logic [7:0] v);
    txWe = 1'b1; txData = v; step(); txWe = 1'b0;
  endtask

  task automatic rxPush(logic [7:0] v);
    rxWe = 1'b1; rxData = v; step(); rxWe = 1'b0;
  endtask

  task automatic rxRead();
    rxRe = 1'b1; step(); rxRe = 1'b0;
  endtask

  // Discard both queues and empty the shift register in one cycle
  task automatic startClean(logic [7:0] mode);
    ctrlWe = 1'b1; ctrlData = mode | 8'h06; txShiftDone = 1'b1;
    step();
    ctrlWe = 1'b0; txShiftDone = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 txCount", txCount, 0);
    chk("R13 rxCount", rxCount, 0);
    chk("R13 fifoMode", fifoMode, 0);
    chk("R13 rxTrig", rxTrig, 0);
    chk("R13 shiftValid", txShiftValid, 0);
    chk("R13 rxDout", rxDout, 0);
  endtask

  task automatic t_plain_mode();
    startClean(8'h00);
    chk("R8 mode off", fifoMode, 0);
    txWrite(8'hA1);
    step();
    chk("R12 load after one edge", txShiftValid, 1);
    chk("R12 loaded byte", txShiftData, 8'hA1);
    txWrite(8'hA2);
    txWrite(8'hA3);
    chk("R8 tx holds one byte", txCount, 1);
    rxPush(8'h31);
    rxPush(8'h32);
    chk("R8 rx holds one byte", rxCount, 1);
    chk("R8 no trigger in plain mode", rxTrig, 0);
    txShiftDone = 1'b1; step(); txShiftDone = 1'b0;
    chk("R12 done clears valid", txShiftValid, 0);
    step();
    chk("R12 next byte loaded", txShiftData, 8'hA2);
    rxRead();
    chk("R8 rx held byte", rxDout, 8'h31);
  endtask

  task automatic t_tx_full_and_clear();
    startClean(8'h01);
    for (int i = 0; i < DEPTH + 1; i++) txWrite(8'h40 + 8'(i));
    chk("R9 queue full", txCount, DEPTH);
    chk("R12 first byte in shifter", txShiftData, 8'h40);
    txWrite(8'hEE);
    chk("R9 extra byte dropped", txCount, DEPTH);
    txShiftDone = 1'b1; step(); txShiftDone = 1'b0;
    step();
    chk("R12 oldest queued byte next", txShiftData, 8'h41);
    chk("R12 one byte left queue", txCount, DEPTH - 1);
    // discard with a character in the shift register, plus a same-cycle host byte
    ctrlWe = 1'b1; ctrlData = 8'h05; txWe = 1'b1; txData = 8'hDD;
    step();
    ctrlWe = 1'b0; txWe = 1'b0;
    chk("R1 tx discarded", txCount, 0);
    chk("R2 shifter valid kept", txShiftValid, 1);
    chk("R2 shifter byte kept", txShiftData, 8'h41);
    txWrite(8'h77);
    txWrite(8'h78);
    ctrlWrite(8'h01);
    chk("R3 no second discard", txCount, 2);
    txShiftDone = 1'b1; step(); txShiftDone = 1'b0;
    step();
    chk("R1 post-discard byte loads", txShiftData, 8'h77);
  endtask

  task automatic t_trigger_levels();
    int lvl [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      startClean(8'h01 | 8'(s << 6));
      chk("R7 empty no trigger", rxTrig, 0);
      for (int k = 1; k <= 15; k++) begin
        rxPush(8'(k));
        chk($sformatf("R6 R7 sel%0d count%0d", s, k), rxTrig, (k >= lvl[s]) ? 1 : 0);
      end
    end
  endtask

  task automatic t_rx_full_and_read();
    startClean(8'h01);
    for (int i = 0; i < DEPTH + 1; i++) rxPush(8'h80 + 8'(i));
    chk("R11 full count", rxCount, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rxRead();
      chk("R11 order", rxDout, 8'h80 + i);
    end
    chk("R10 drained", rxCount, 0);
    rxRead();
    chk("R10 empty read keeps data", rxDout, 8'h8F);
    chk("R10 empty read keeps count", rxCount, 0);
  endtask

  task automatic t_rx_clear();
    startClean(8'h01);
    txShiftDone = 1'b0;
    txWrite(8'h11);
    txWrite(8'h12);
    rxPush(8'h51); rxPush(8'h52); rxPush(8'h53);
    rxRead();
    chk("R10 read value", rxDout, 8'h51);
    ctrlWrite(8'h03);
    chk("R4 rx discarded", rxCount, 0);
    chk("R4 rxDout kept", rxDout, 8'h51);
    chk("R4 tx untouched", txCount, 1);
    rxPush(8'h60);
    rxRead();
    chk("R4 fresh data after discard", rxDout, 8'h60);
  endtask

  task automatic t_ignored_bits();
    startClean(8'h01);
    rxPush(8'h01); rxPush(8'h02);
    txWrite(8'h21); txWrite(8'h22); txWrite(8'h23);
    ctrlWrite(8'h39);
    chk("R5 mode on", fifoMode, 1);
    chk("R5 level one kept", rxTrig, 1);
    chk("R5 rx count kept", rxCount, 2);
    chk("R5 tx count kept", txCount, 2);
    ctrlWrite(8'h79);
    chk("R5 level four", rxTrig, 0);
    chk("R5 rx count kept again", rxCount, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_mode();
    t_tx_full_and_clear();
    t_trigger_levels();
    t_rx_full_and_read();
    t_rx_clear();
    t_ignored_bits();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FIFO-CTRL FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule